// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block sits beside the execute stage of a five-stage in-order pipeline and decides, for each of the two ALU operands, where the operand value should come from. It compares the two source register numbers of the instruction now in execute with the destination register numbers of the two older instructions still in flight. One is in the memory stage and the other is in the write-back stage. It produces one 2-bit mux select per operand.

A select of 2'b00 keeps the value read from the register file. A select of 2'b10 takes the result held at the memory-stage boundary. A select of 2'b01 takes the result held at the write-back-stage boundary. An older instruction is a candidate source only if it writes a register and its destination is not register zero. When both older instructions target the same source register, the memory-stage result is used because it is the newer one. The unit has no clock and no storage, so the selects follow the inputs within the same cycle.

There is no state register. The selection for each operand is a fixed priority with three named outcomes: REGFILE, LATE (write-back) and NEAR (memory stage). NEAR has the highest priority, then LATE, then REGFILE.

Top module: `opfwd_unit`

## Requirements
- R1: When `mem_wr_en` is 1, `mem_dst` is nonzero and `mem_dst` equals `ex_src_a`, `opnd_a_sel` is 2'b10. The same rule applied to `ex_src_b` sets `opnd_b_sel` to 2'b10.
- R2: When `wb_wr_en` is 1, `wb_dst` is nonzero, `wb_dst` equals `ex_src_a`, and R1 does not apply to operand A, `opnd_a_sel` is 2'b01. Operand B follows the same rule using `ex_src_b`.
- R3: A stage whose write-enable input is 0 never causes a select that points at that stage, whatever its destination number is.
- R4: A destination number of 0 never causes forwarding from either stage.
- R5: When both stages qualify for the same operand, the select is 2'b10. The memory-stage result wins over the write-back result.
- R6: When neither stage qualifies for an operand, its select is 2'b00 (register file value). The code 2'b11 is never produced.
- R7: The two selects are computed independently of each other. When `ex_src_a` equals `ex_src_b`, both selects take the same value.
- R8: Register numbers are 5 bits wide. The selects are purely combinational, so they reflect the current inputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_a | input | 5 | First source register number of the execute-stage instruction |
| ex_src_b | input | 5 | Second source register number of the execute-stage instruction |
| mem_dst | input | 5 | Destination register number of the memory-stage instruction |
| mem_wr_en | input | 1 | Memory-stage instruction writes a register |
| wb_dst | input | 5 | Destination register number of the write-back-stage instruction |
| wb_wr_en | input | 1 | Write-back-stage instruction writes a register |
| opnd_a_sel | output | 2 | Source select for operand A (00 register file, 01 write-back, 10 memory stage) |
| opnd_b_sel | output | 2 | Source select for operand B, same encoding |

## Verification
The main function is tested with input patterns that each separate one pair of outcomes:
- A match in only one stage shows which stage was chosen.
- A match with the write enable low shows that the write enable is respected.
- Matching both stages shows the newer-wins priority.
- Setting the source numbers equal, or different, shows that the two operands do not interfere.

A sweep of every register number against a writing memory stage isolates register zero as the only number that never forwards. A second pattern, where the memory stage targets register zero and the write-back stage targets the real register, shows that a register-zero match in the memory stage does not block the write-back path.

// File: rtl/opfwd_pkg.sv
package opfwd_pkg;
    localparam int REG_W   = 5;
    localparam int NUM_SRC = 2;

    typedef enum logic [1:0] {
        SRC_REGFILE = 2'b00,
        SRC_LATE    = 2'b01,
        SRC_NEAR    = 2'b10
    } opnd_src_e;
endpackage

// File: rtl/opfwd_hit.sv
module opfwd_hit #(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] src,
    input  logic [REG_W-1:0] dst,
    input  logic             wr_en,
    output logic             hit
);
    localparam logic [REG_W-1:0] ZERO_REG = '0;

    always_comb begin
        hit = wr_en && (dst != ZERO_REG) && (dst == src);
    end
endmodule

// File: rtl/opfwd_pick.sv
module opfwd_pick
    import opfwd_pkg::*;
(
    input  logic      near_hit,
    input  logic      late_hit,
    output opnd_src_e sel
);
    always_comb begin
        unique case ({near_hit, late_hit})
            2'b10, 2'b11: sel = SRC_NEAR;
            2'b01:        sel = SRC_LATE;
            default:      sel = SRC_REGFILE;
        endcase
    end
endmodule

// File: rtl/opfwd_unit.sv
module opfwd_unit
    import opfwd_pkg::*;
(
    input  logic [4:0] ex_src_a,
    input  logic [4:0] ex_src_b,
    input  logic [4:0] mem_dst,
    input  logic       mem_wr_en,
    input  logic [4:0] wb_dst,
    input  logic       wb_wr_en,
    output logic [1:0] opnd_a_sel,
    output logic [1:0] opnd_b_sel
);
    logic [REG_W-1:0] src_vec  [NUM_SRC];
    opnd_src_e        sel_vec  [NUM_SRC];
    logic             near_vec [NUM_SRC];
    logic             late_vec [NUM_SRC];

    always_comb begin
        src_vec[0] = ex_src_a;
        src_vec[1] = ex_src_b;
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_opnd
        opfwd_hit #(.REG_W(REG_W)) u_near (
            .src(src_vec[i]), .dst(mem_dst), .wr_en(mem_wr_en), .hit(near_vec[i])
        );
        opfwd_hit #(.REG_W(REG_W)) u_late (
            .src(src_vec[i]), .dst(wb_dst), .wr_en(wb_wr_en), .hit(late_vec[i])
        );
        opfwd_pick u_pick (
            .near_hit(near_vec[i]), .late_hit(late_vec[i]), .sel(sel_vec[i])
        );

        always_comb begin
            // R1
            near_fwd_chk: assert (!(near_vec[i]) || sel_vec[i] == SRC_NEAR);
            // R3
            no_wr_near_chk: assert (mem_wr_en || sel_vec[i] != SRC_NEAR);
            // R3
            no_wr_late_chk: assert (wb_wr_en || sel_vec[i] != SRC_LATE);
            // R4
            zero_reg_chk: assert (src_vec[i] != '0 || sel_vec[i] == SRC_REGFILE);
            // R5
            newest_wins_chk: assert (!(near_vec[i] && late_vec[i]) || sel_vec[i] == SRC_NEAR);
            // R6
            legal_code_chk: assert (sel_vec[i] != opnd_src_e'(2'b11));
        end
    end

    always_comb begin
        opnd_a_sel = sel_vec[0];
        opnd_b_sel = sel_vec[1];
    end

    always_comb begin
        // R7
        same_src_chk: assert (ex_src_a != ex_src_b || opnd_a_sel == opnd_b_sel);
    end
endmodule

// File: tb/opfwd_unit_test.sv
module opfwd_unit_test;
    localparam int PERIOD   = 10;
    localparam int WATCHDOG = 5000;
    localparam int NVEC     = 15;

    // fields: req(4) src_a(5) src_b(5) mem_dst(5) mem_wr(1) wb_dst(5) wb_wr(1) exp_a(2) exp_b(2)
    localparam logic [29:0] VEC [NVEC] = '{
        {4'd6, 5'd0,  5'd0,  5'd0,  1'b0, 5'd0,  1'b0, 2'b00, 2'b00}, // R6 idle
        {4'd1, 5'd2,  5'd5,  5'd2,  1'b1, 5'd9,  1'b1, 2'b10, 2'b00}, // R1 on A
        {4'd1, 5'd6,  5'd2,  5'd2,  1'b1, 5'd7,  1'b1, 2'b00, 2'b10}, // R1 on B
        {4'd2, 5'd2,  5'd5,  5'd7,  1'b1, 5'd2,  1'b1, 2'b01, 2'b00}, // R2 on A
        {4'd2, 5'd6,  5'd2,  5'd0,  1'b0, 5'd2,  1'b1, 2'b00, 2'b01}, // R2 on B
        {4'd3, 5'd2,  5'd2,  5'd2,  1'b0, 5'd2,  1'b0, 2'b00, 2'b00}, // R3 both off
        {4'd3, 5'd3,  5'd4,  5'd3,  1'b0, 5'd4,  1'b1, 2'b00, 2'b01}, // R3 near off
        {4'd4, 5'd0,  5'd0,  5'd0,  1'b1, 5'd0,  1'b1, 2'b00, 2'b00}, // R4 zero
        {4'd5, 5'd1,  5'd1,  5'd1,  1'b1, 5'd1,  1'b1, 2'b10, 2'b10}, // R5 both
        {4'd5, 5'd1,  5'd3,  5'd1,  1'b1, 5'd1,  1'b1, 2'b10, 2'b00}, // R5 A only
        {4'd7, 5'd4,  5'd8,  5'd8,  1'b1, 5'd4,  1'b1, 2'b01, 2'b10}, // R7 split
        {4'd7, 5'd9,  5'd9,  5'd3,  1'b1, 5'd9,  1'b1, 2'b01, 2'b01}, // R7 equal
        {4'd3, 5'd5,  5'd6,  5'd5,  1'b0, 5'd5,  1'b1, 2'b01, 2'b00}, // R3 late wins
        {4'd4, 5'd7,  5'd7,  5'd0,  1'b1, 5'd7,  1'b1, 2'b01, 2'b01}, // R4 zero near
        {4'd6, 5'd10, 5'd11, 5'd12, 1'b1, 5'd13, 1'b1, 2'b00, 2'b00}  // R6 miss
    };

    logic       clk = 1'b0;
    logic [4:0] ex_src_a, ex_src_b, mem_dst, wb_dst;
    logic       mem_wr_en, wb_wr_en;
    logic [1:0] opnd_a_sel, opnd_b_sel;
    int         n_chk  = 0;
    int         n_fail = 0;
    bit         done   = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    opfwd_unit uut (
        .ex_src_a(ex_src_a), .ex_src_b(ex_src_b),
        .mem_dst(mem_dst), .mem_wr_en(mem_wr_en),
        .wb_dst(wb_dst), .wb_wr_en(wb_wr_en),
        .opnd_a_sel(opnd_a_sel), .opnd_b_sel(opnd_b_sel)
    );

    task automatic apply(input logic [4:0] a, input logic [4:0] b,
                         input logic [4:0] md, input logic mw,
                         input logic [4:0] wd, input logic ww);
        @(posedge clk);
        ex_src_a = a; ex_src_b = b;
        mem_dst = md; mem_wr_en = mw;
        wb_dst = wd; wb_wr_en = ww;
        @(negedge clk);
    endtask

    task automatic check(input int req, input logic [1:0] ea, input logic [1:0] eb);
        n_chk++;
        if (opnd_a_sel !== ea || opnd_b_sel !== eb) begin
            n_fail++;
            $display("FAIL R%0d: got a=%b b=%b expected a=%b b=%b", req,
                     opnd_a_sel, opnd_b_sel, ea, eb);
        end
    endtask

    initial begin
        // R6: quiet inputs give the register-file select
        apply(5'd0, 5'd0, 5'd0, 1'b0, 5'd0, 1'b0);
        check(6, 2'b00, 2'b00);

        for (int i = 0; i < NVEC; i++) begin
            apply(VEC[i][25:21], VEC[i][20:16], VEC[i][15:11], VEC[i][10],
                  VEC[i][9:5], VEC[i][4]);
            check(int'(VEC[i][29:26]), VEC[i][3:2], VEC[i][1:0]);
        end

        // R4 and R1: sweep every register number against a writing memory stage
        for (int r = 0; r < 32; r++) begin
            apply(5'(r), 5'(r), 5'(r), 1'b1, 5'd0, 1'b0);
            check(r == 0 ? 4 : 1, r == 0 ? 2'b00 : 2'b10, r == 0 ? 2'b00 : 2'b10);
        end

        // R8: selects follow an input change with no clock edge in between
        @(negedge clk);
        ex_src_a = 5'd17; ex_src_b = 5'd18;
        mem_dst = 5'd17; mem_wr_en = 1'b1; wb_dst = 5'd18; wb_wr_en = 1'b1;
        #1;
        check(8, 2'b10, 2'b01);
        mem_wr_en = 1'b0;
        #1;
        check(8, 2'b00, 2'b01);

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < WATCHDOG && !done; c++) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got hung run expected completion");
        end
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule